// File: doc/BRIEF.md
# Scrolling Text Cell Store and Scan Mapper

This block holds the character cells of an 80-column, 60-line text terminal and turns each raster pixel position of a 640x480 scan into a cell lookup. The writer side puts 8-bit character codes into cells and records how long each row was when the cursor left it. The scan side supplies the pixel coordinate together with the current cursor row and column. One cycle later the block returns the character code under that pixel, whether the cell is to be drawn, and the pixel's position inside its 8x8 glyph.

Rows are kept as a ring. The screen origin is tied to the cursor row, so the cursor's row is always the bottom text line and older rows sit above it, oldest at the top. Scrolling therefore needs no data movement. Reused rows are never cleared. Instead, cells at or past a row's recorded length are blanked. On the cursor's own row the cursor column sets the limit, because that row's stored length may be left over from an earlier trip around the ring.

A glyph table outside the block is reached through a combinational port. The block presents the code and glyph line, and it receives the 8-pixel row bitmap back to form the final pixel.

Top module: `text_ring_view`

## Requirements
- R1: While reset is asserted, and until the first scan sample after reset, `cell_visible`, `pixel_on`, `glyph_code`, `glyph_x` and `glyph_y` are all zero.
- R2: A write with `cell_we` high stores `cell_wdata` at column `cell_waddr[12:6]` and row `cell_waddr[5:0]`. A scan of that cell returns the code on `glyph_code` one cycle after the scan coordinate is sampled.
- R3: Text line L = `scan_y[8:3]` shows ring row (`cur_row` + 1 + L) mod 60. Line 59 therefore shows `cur_row`, and line 0 shows the row after it, wrapping from 59 to 0.
- R4: The cell column is `scan_x[9:3]`. `glyph_x` = `scan_x[2:0]` and `glyph_y` = `scan_y[2:0]`, and both are delayed by one cycle to align with `glyph_code`.
- R5: On any line other than 59, a cell is visible only when its column is below the row length most recently written for that row through `len_we`/`len_waddr`/`len_wdata`. Stale codes at or past that length stay hidden.
- R6: On line 59 (the cursor row), a cell is visible only when its column is below the `cur_col` sampled with the coordinate. The stored length of that row has no effect.
- R7: A coordinate with `scan_x` >= 640 or `scan_y` >= 480 is never visible.
- R8: When a cell is written in the same cycle as it is scanned, the scan returns the previous code. A scan in the following cycle returns the new code.
- R9: `font_addr` = {`glyph_code`, `glyph_y`}. `pixel_on` = `cell_visible` AND `font_row[7 - glyph_x]`, so bit 7 is the leftmost pixel.
- R10: A cell write whose column field is 80 or more, or whose row field is 60 or more, changes no stored cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_we | input | 1 | Character cell write strobe |
| cell_waddr | input | 13 | Write address: column in [12:6], row in [5:0] |
| cell_wdata | input | 8 | Character code to store |
| len_we | input | 1 | Row length write strobe |
| len_waddr | input | 6 | Row whose length is written |
| len_wdata | input | 7 | Row length, 0 to 80 |
| cur_row | input | 6 | Ring row holding the cursor |
| cur_col | input | 7 | Cursor column |
| scan_x | input | 10 | Raster pixel column |
| scan_y | input | 9 | Raster pixel line |
| glyph_code | output | 8 | Character code under the pixel (one-cycle latency) |
| cell_visible | output | 1 | Cell is to be drawn |
| glyph_x | output | 3 | Pixel column inside the glyph |
| glyph_y | output | 3 | Pixel line inside the glyph |
| font_addr | output | 11 | Glyph table address: code and glyph line |
| font_row | input | 8 | Glyph table row bitmap, bit 7 leftmost |
| pixel_on | output | 1 | Final foreground pixel |

## Verification
A cell write and a scan read can hit the same storage location in the same cycle. The bench provokes this by driving a write strobe to a cell that already holds a known code while the scan coordinate points at that same cell. It expects the old code in that cycle and the new code when the coordinate is held for one more cycle. The cursor-row limit and the stored-length limit can also both apply to one row. The bench places a large stale length on the cursor's row and expects only the cursor column to decide visibility there.

// File: rtl/trv_pkg.sv
package trv_pkg;
    localparam int TRV_COLS    = 80;
    localparam int TRV_ROWS    = 60;
    localparam int TRV_CELL_PX = 8;
    localparam int TRV_CODE_W  = 8;
endpackage

// File: rtl/trv_scan_map.sv
module trv_scan_map #(
    parameter int COLS    = trv_pkg::TRV_COLS,
    parameter int ROWS    = trv_pkg::TRV_ROWS,
    parameter int CELL_PX = trv_pkg::TRV_CELL_PX
) (
    input  logic [$clog2(COLS)+$clog2(CELL_PX)-1:0] scan_x,
    input  logic [$clog2(ROWS)+$clog2(CELL_PX)-1:0] scan_y,
    input  logic [$clog2(ROWS)-1:0]                 cur_row,
    output logic [$clog2(ROWS)-1:0]                 buf_row,
    output logic [$clog2(COLS)-1:0]                 cell_col,
    output logic [$clog2(CELL_PX)-1:0]              sub_x,
    output logic [$clog2(CELL_PX)-1:0]              sub_y,
    output logic                                    in_range,
    output logic                                    on_cursor_line
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int GLY_W = $clog2(CELL_PX);
    localparam int SUM_W = ROW_W + 2;

    logic [COL_W-1:0] col_raw;
    logic [ROW_W-1:0] line_raw;
    logic [SUM_W-1:0] ring_sum;
    logic [SUM_W-1:0] ring_wrapped;

    always_comb begin
        col_raw  = scan_x[COL_W+GLY_W-1:GLY_W];
        line_raw = scan_y[ROW_W+GLY_W-1:GLY_W];
        sub_x    = scan_x[GLY_W-1:0];
        sub_y    = scan_y[GLY_W-1:0];

        in_range       = (col_raw < COL_W'(COLS)) && (line_raw < ROW_W'(ROWS));
        on_cursor_line = (line_raw == ROW_W'(ROWS - 1));

        // oldest row sits on line 0: origin is one past the cursor row
        ring_sum = SUM_W'(cur_row) + SUM_W'(1) + SUM_W'(line_raw);
        if (ring_sum >= SUM_W'(ROWS)) begin
            ring_wrapped = ring_sum - SUM_W'(ROWS);
        end else begin
            ring_wrapped = ring_sum;
        end

        buf_row  = in_range ? ring_wrapped[ROW_W-1:0] : '0;
        cell_col = in_range ? col_raw : '0;
    end
endmodule

// File: rtl/trv_cell_store.sv
module trv_cell_store #(
    parameter int COLS   = trv_pkg::TRV_COLS,
    parameter int ROWS   = trv_pkg::TRV_ROWS,
    parameter int CODE_W = trv_pkg::TRV_CODE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(COLS)-1:0] wr_col,
    input  logic [$clog2(ROWS)-1:0] wr_row,
    input  logic [CODE_W-1:0]       wr_code,
    input  logic [$clog2(COLS)-1:0] rd_col,
    input  logic [$clog2(ROWS)-1:0] rd_row,
    output logic [CODE_W-1:0]       rd_code
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int DEPTH = COLS * ROWS;
    localparam int IDX_W = $clog2(DEPTH);

    function automatic logic [IDX_W-1:0] flat_index(input logic [ROW_W-1:0] r,
                                                    input logic [COL_W-1:0] c);
        return IDX_W'(r) * IDX_W'(COLS) + IDX_W'(c);
    endfunction

    logic [CODE_W-1:0] cells [DEPTH];
    logic              wr_ok;
    logic              rd_ok;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [CODE_W-1:0] rd_d;
    logic [CODE_W-1:0] rd_q;

    always_comb begin
        wr_ok  = wr_en && (wr_col < COL_W'(COLS)) && (wr_row < ROW_W'(ROWS));
        rd_ok  = (rd_col < COL_W'(COLS)) && (rd_row < ROW_W'(ROWS));
        wr_idx = flat_index(wr_row, wr_col);
        rd_idx = flat_index(rd_row, rd_col);
        rd_d   = rd_ok ? cells[rd_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            cells[wr_idx] <= wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_code = rd_q;

    // R2: an accepted write is present in the array on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> cells[$past(wr_idx)] == $past(wr_code));
endmodule

// File: rtl/trv_len_store.sv
module trv_len_store #(
    parameter int COLS = trv_pkg::TRV_COLS,
    parameter int ROWS = trv_pkg::TRV_ROWS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(ROWS)-1:0]   wr_row,
    input  logic [$clog2(COLS+1)-1:0] wr_len,
    input  logic [$clog2(ROWS)-1:0]   rd_row,
    output logic [$clog2(COLS+1)-1:0] rd_len
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int LEN_W = $clog2(COLS + 1);

    logic [LEN_W-1:0] lengths [ROWS];
    logic             wr_ok;
    logic [LEN_W-1:0] rd_d;
    logic [LEN_W-1:0] rd_q;

    always_comb begin
        wr_ok = wr_en && (wr_row < ROW_W'(ROWS));
        rd_d  = (rd_row < ROW_W'(ROWS)) ? lengths[rd_row] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            lengths[wr_row] <= wr_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_len = rd_q;

    // R5: a recorded length is held for later reads of that row
    assert_len_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> lengths[$past(wr_row)] == $past(wr_len));
endmodule

// File: rtl/text_ring_view.sv
module text_ring_view #(
    parameter int COLS    = trv_pkg::TRV_COLS,
    parameter int ROWS    = trv_pkg::TRV_ROWS,
    parameter int CELL_PX = trv_pkg::TRV_CELL_PX,
    parameter int CODE_W  = trv_pkg::TRV_CODE_W
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cell_we,
    input  logic [$clog2(COLS)+$clog2(ROWS)-1:0]          cell_waddr,
    input  logic [CODE_W-1:0]                             cell_wdata,
    input  logic                                          len_we,
    input  logic [$clog2(ROWS)-1:0]                       len_waddr,
    input  logic [$clog2(COLS+1)-1:0]                     len_wdata,
    input  logic [$clog2(ROWS)-1:0]                       cur_row,
    input  logic [$clog2(COLS)-1:0]                       cur_col,
    input  logic [$clog2(COLS)+$clog2(CELL_PX)-1:0]       scan_x,
    input  logic [$clog2(ROWS)+$clog2(CELL_PX)-1:0]       scan_y,
    output logic [CODE_W-1:0]                             glyph_code,
    output logic                                          cell_visible,
    output logic [$clog2(CELL_PX)-1:0]                    glyph_x,
    output logic [$clog2(CELL_PX)-1:0]                    glyph_y,
    output logic [CODE_W+$clog2(CELL_PX)-1:0]             font_addr,
    input  logic [CELL_PX-1:0]                            font_row,
    output logic                                          pixel_on
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int GLY_W = $clog2(CELL_PX);
    localparam int LEN_W = $clog2(COLS + 1);

    typedef struct packed {
        logic             in_range;
        logic             on_cursor;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] limit_col;
        logic [GLY_W-1:0] gx;
        logic [GLY_W-1:0] gy;
    } pix_ctx_t;

    logic [ROW_W-1:0] map_row;
    logic [COL_W-1:0] map_col;
    logic [GLY_W-1:0] map_gx;
    logic [GLY_W-1:0] map_gy;
    logic             map_in_range;
    logic             map_on_cursor;
    logic [LEN_W-1:0] row_len;
    logic [CODE_W-1:0] code_rd;

    pix_ctx_t ctx_d;
    pix_ctx_t ctx_q;

    trv_scan_map #(
        .COLS(COLS), .ROWS(ROWS), .CELL_PX(CELL_PX)
    ) map_i (
        .scan_x        (scan_x),
        .scan_y        (scan_y),
        .cur_row       (cur_row),
        .buf_row       (map_row),
        .cell_col      (map_col),
        .sub_x         (map_gx),
        .sub_y         (map_gy),
        .in_range      (map_in_range),
        .on_cursor_line(map_on_cursor)
    );

    trv_cell_store #(
        .COLS(COLS), .ROWS(ROWS), .CODE_W(CODE_W)
    ) cells_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cell_we),
        .wr_col (cell_waddr[COL_W+ROW_W-1:ROW_W]),
        .wr_row (cell_waddr[ROW_W-1:0]),
        .wr_code(cell_wdata),
        .rd_col (map_col),
        .rd_row (map_row),
        .rd_code(code_rd)
    );

    trv_len_store #(
        .COLS(COLS), .ROWS(ROWS)
    ) lens_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (len_we),
        .wr_row(len_waddr),
        .wr_len(len_wdata),
        .rd_row(map_row),
        .rd_len(row_len)
    );

    // next-state: pixel context travels alongside the memory reads
    always_comb begin
        ctx_d.in_range  = map_in_range;
        ctx_d.on_cursor = map_on_cursor;
        ctx_d.col       = map_col;
        ctx_d.limit_col = cur_col;
        ctx_d.gx        = map_gx;
        ctx_d.gy        = map_gy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        if (!ctx_q.in_range) begin
            cell_visible = 1'b0;
        end else if (ctx_q.on_cursor) begin
            cell_visible = ctx_q.col < ctx_q.limit_col;
        end else begin
            cell_visible = LEN_W'(ctx_q.col) < row_len;
        end
        glyph_code = code_rd;
        glyph_x    = ctx_q.gx;
        glyph_y    = ctx_q.gy;
        font_addr  = {code_rd, ctx_q.gy};
        pixel_on   = cell_visible && font_row[GLY_W'(CELL_PX - 1) - ctx_q.gx];
    end

    // R4: glyph-local coordinates trail the scan input by one cycle
    assert_glyph_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (glyph_x == $past(scan_x[GLY_W-1:0]) &&
                          glyph_y == $past(scan_y[GLY_W-1:0])));

    // R7: nothing outside the text raster is drawn
    assert_raster_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cell_visible) |->
            ($past(scan_x[COL_W+GLY_W-1:GLY_W]) < COL_W'(COLS) &&
             $past(scan_y[ROW_W+GLY_W-1:GLY_W]) < ROW_W'(ROWS)));

    // R6: on the bottom line only cells left of the cursor are drawn
    assert_cursor_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cell_visible &&
         $past(scan_y[ROW_W+GLY_W-1:GLY_W]) == ROW_W'(ROWS - 1)) |->
            ($past(scan_x[COL_W+GLY_W-1:GLY_W]) < $past(cur_col)));

    // R9: a lit pixel requires a visible cell
    assert_pixel_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_on |-> cell_visible);
endmodule

// File: tb/text_ring_view_tb.sv
module text_ring_view_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_we = 1'b0;
    logic [12:0] cell_waddr = '0;
    logic [7:0]  cell_wdata = '0;
    logic        len_we = 1'b0;
    logic [5:0]  len_waddr = '0;
    logic [6:0]  len_wdata = '0;
    logic [5:0]  cur_row = '0;
    logic [6:0]  cur_col = '0;
    logic [9:0]  scan_x = '0;
    logic [8:0]  scan_y = '0;
    logic [7:0]  glyph_code;
    logic        cell_visible;
    logic [2:0]  glyph_x;
    logic [2:0]  glyph_y;
    logic [10:0] font_addr;
    logic [7:0]  font_row;
    logic        pixel_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_char [60][80];
    logic [6:0] m_len  [60];

    always #2 clk = ~clk;

    // glyph table stand-in: bitmap derived from the address
    assign font_row = font_addr[10:3] ^ {font_addr[2:0], 5'b0};

    text_ring_view dut_i (
        .clk(clk), .rst_n(rst_n),
        .cell_we(cell_we), .cell_waddr(cell_waddr), .cell_wdata(cell_wdata),
        .len_we(len_we), .len_waddr(len_waddr), .len_wdata(len_wdata),
        .cur_row(cur_row), .cur_col(cur_col),
        .scan_x(scan_x), .scan_y(scan_y),
        .glyph_code(glyph_code), .cell_visible(cell_visible),
        .glyph_x(glyph_x), .glyph_y(glyph_y),
        .font_addr(font_addr), .font_row(font_row), .pixel_on(pixel_on)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_raw(input int col, input int row, input logic [7:0] code);
        @(negedge clk);
        cell_we = 1'b1; cell_waddr = {7'(col), 6'(row)}; cell_wdata = code;
        @(posedge clk); #1;
        cell_we = 1'b0;
        if (col < 80 && row < 60) m_char[row][col] = code;
    endtask

    task automatic write_len(input int row, input int len);
        @(negedge clk);
        len_we = 1'b1; len_waddr = 6'(row); len_wdata = 7'(len);
        @(posedge clk); #1;
        len_we = 1'b0;
        m_len[row] = 7'(len);
    endtask

    task automatic scan(input int col, input int line, input int gx, input int gy);
        @(negedge clk);
        scan_x = 10'(col * 8 + gx); scan_y = 9'(line * 8 + gy);
        @(posedge clk); #1;
    endtask

    task automatic expect_cell(input string tag, input int col, input int line,
                               input int gx, input int gy);
        int br;
        bit vis;
        logic [7:0] bits;
        br = (int'(cur_row) + 1 + line) % 60;
        if (col >= 80 || line >= 60) vis = 0;
        else if (line == 59) vis = (col < int'(cur_col));
        else vis = (col < int'(m_len[br]));
        scan(col, line, gx, gy);
        chk({tag, " visible"}, 16'(cell_visible), 16'(vis));
        chk({tag, " glyph_x R4"}, 16'(glyph_x), 16'(gx));
        chk({tag, " glyph_y R4"}, 16'(glyph_y), 16'(gy));
        if (vis) begin
            chk({tag, " code"}, 16'(glyph_code), 16'(m_char[br][col]));
            chk({tag, " font_addr R9"}, 16'(font_addr), 16'({m_char[br][col], 3'(gy)}));
            bits = m_char[br][col] ^ {3'(gy), 5'b0};
            chk({tag, " pixel R9"}, 16'(pixel_on), 16'(bits[7 - gx]));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 visible in reset", 16'(cell_visible), 16'h0);
        chk("R1 pixel in reset", 16'(pixel_on), 16'h0);
        chk("R1 code in reset", 16'(glyph_code), 16'h0);
        chk("R1 glyph_x in reset", 16'({glyph_x, glyph_y}), 16'h0);
        rst_n = 1'b1;
        for (int r = 0; r < 60; r++) write_len(r, 0);
    endtask

    task automatic t_rows;
        cur_row = 6'd10; cur_col = 7'd0;
        for (int c = 0; c < 10; c++) write_raw(c, 5, 8'h41 + 8'(c));
        write_raw(20, 5, 8'h5a);
        write_len(5, 10);
        expect_cell("R2 R3 row5 col0", 0, 54, 0, 0);
        expect_cell("R2 R5 row5 col4", 4, 54, 3, 2);
        expect_cell("R5 row5 col9 last", 9, 54, 7, 7);
        expect_cell("R5 row5 col10 beyond", 10, 54, 0, 0);
        expect_cell("R5 row5 stale col20", 20, 54, 1, 1);
    endtask

    task automatic t_cursor;
        cur_row = 6'd10;
        write_raw(0, 10, 8'h71);
        write_raw(2, 10, 8'h72);
        write_raw(50, 10, 8'h73);
        write_len(10, 70);
        cur_col = 7'd3;
        expect_cell("R3 R6 cursor row col0", 0, 59, 2, 4);
        expect_cell("R6 cursor row col2", 2, 59, 5, 1);
        expect_cell("R6 cursor col3 hidden", 3, 59, 0, 0);
        expect_cell("R6 stale len ignored col50", 50, 59, 0, 0);
        write_len(10, 0);
        cur_col = 7'd51;
        expect_cell("R6 len0 ignored col50", 50, 59, 6, 3);
    endtask

    task automatic t_wrap;
        cur_row = 6'd58; cur_col = 7'd0;
        write_raw(0, 59, 8'h61);
        write_raw(79, 0, 8'h62);
        write_len(59, 1);
        write_len(0, 80);
        expect_cell("R3 wrap line0 row59", 0, 0, 1, 0);
        expect_cell("R3 wrap line1 row0 col79", 79, 1, 7, 6);
        cur_row = 6'd59;
        expect_cell("R3 cur59 line0 row0", 79, 0, 4, 4);
    endtask

    task automatic t_range;
        cur_row = 6'd58;
        expect_cell("R7 x=640", 80, 0, 0, 0);
        expect_cell("R7 y=480", 0, 60, 0, 0);
        expect_cell("R7 far corner", 127, 63, 7, 7);
    endtask

    task automatic t_collide;
        cur_row = 6'd10;
        @(negedge clk);
        cell_we = 1'b1; cell_waddr = {7'd4, 6'd5}; cell_wdata = 8'h77;
        scan_x = 10'(4 * 8); scan_y = 9'(54 * 8);
        @(posedge clk); #1;
        chk("R8 same-cycle read old", 16'(glyph_code), 16'(m_char[5][4]));
        @(negedge clk);
        cell_we = 1'b0;
        @(posedge clk); #1;
        chk("R8 next-cycle read new", 16'(glyph_code), 16'h77);
        m_char[5][4] = 8'h77;
    endtask

    task automatic t_ignore;
        cur_row = 6'd10;
        write_raw(0, 1, 8'h6b);
        write_len(1, 5);
        write_raw(80, 0, 8'h58);
        write_raw(127, 63, 8'h59);
        write_raw(0, 60, 8'h5b);
        expect_cell("R10 row1 col0 untouched", 0, 50, 0, 0);
        expect_cell("R10 row5 col0 untouched", 0, 54, 0, 0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_rows();
        t_cursor();
        t_wrap();
        t_range();
        t_collide();
        t_ignore();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finish_run();
        end
    end
endmodule